// File: doc/BRIEF.md
# Exception Entry State Generator

This block computes everything a processor core must commit on the cycle it enters an exception handler. Its inputs are an exception code, a two-bit error subcode, the current program counter and the current machine state word, plus a few control fields: the embedded-model select, the power-save wakeup flag and the two-bit high-address relocation mode. On a one-cycle `take` strobe it writes one of three save-register pairs: the standard pair, the hypervisor pair or the critical pair. In the same edge it loads the new program counter and the new machine state word.

The handler address is read from a small vector table. The table is written through a simple write port and is indexed by the effective exception code. The entry is ORed with a prefix, and an optional high-address relocation may be added. A wakeup from a power-save state sends every exception except machine check to the reset entry, and the saved state records the wake reason. Some events leave every output untouched: a floating-point program exception that the state word masks, and an exception whose table entry is undefined.

Bit positions below are counted from the least significant bit of the 64-bit state word. The bits used are: hypervisor 60, floating-point available 13, machine-check enable 12, FP mode bits 11 and 8, instruction translation 5, data translation 4, recoverable 1. The exception codes are: 0 reset, 1 machine check, 2 external, 3 decrementer, 4 doorbell, 5 hypervisor doorbell, 6 hypervisor maintenance, 7 program, 8 system call, 9 hypervisor storage, 10 hypervisor decrementer, 11 critical input, 12 to 15 plain.

Top module: `exc_entry_gen`

## Requirements
- R1: After synchronous reset, every save register, `new_pc`, `new_state`, `checkstop` and `vec_err` read zero.
- R2: The saved PC equals `cur_pc`. The saved state is `cur_state` with mask 0x783F0000 cleared when `embedded_model` is 0, and `cur_state` unchanged when it is 1.
- R3: When no rule below adds bits, `new_state` keeps only bits 12 and 60 of `cur_state`, and every other bit is zero.
- R4: For a program exception (code 7), `exc_sub` selects a bit ORed into the saved state: 0 gives 0x100000, 1 gives 0x80000, 2 gives 0x40000 and 3 gives 0x20000.
- R5: A program exception with `exc_sub`=0 changes no output when bits 11 and 8 are both 0, or when bit 13 is 0.
- R6: A system call (code 8) saves `cur_pc`+4. When `exc_sub[0]` is 1, it also sets bit 60 of `new_state`.
- R7: Codes 5, 6, 9 and 10 write the hypervisor pair, set bit 60 and copy bit 1 of `cur_state` into `new_state`. The other pairs hold their values.
- R8: Code 11 writes the critical pair, and the other pairs hold their values.
- R9: A machine check (code 1) clears bit 12 of `new_state`. If bit 12 was 0 beforehand, `checkstop` rises and stays high until reset.
- R10: With `pm_wake` high, bit 16 of the saved state is set. For any code other than 1, a 4-bit cause goes into bits 21..18 and the reset entry (code 0) is taken. The causes are: code 0 gives 4, 2 gives 8, 3 gives 6, 4 gives 5, 5 gives 3, 6 gives 0xA, and any other code gives 0.
- R11: `new_pc` equals the table entry of the effective code ORed with `vec_prefix`.
- R12: Relocation mode 1 ORs 0x18000 into `new_pc`, and mode 3 ORs 0xC000000000004000. Either mode sets bits 5 and 4 of `new_state`. Modes 0 and 2 add nothing.
- R13: Relocation is not applied when bit 5 or bit 4 of `cur_state` is 0. It is also not applied when `new_state` bit 60 is set while `cur_state` bit 60 is clear.
- R14: A table entry of all ones pulses `vec_err` for one cycle, and no other output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Vector table write enable |
| tbl_addr | input | 4 | Vector table write index |
| tbl_data | input | XLEN | Vector table write data |
| take | input | 1 | Exception entry strobe |
| exc_code | input | 4 | Exception code |
| exc_sub | input | 2 | Error subcode (program kind or system call level) |
| cur_pc | input | XLEN | Current program counter |
| cur_state | input | XLEN | Current machine state word |
| vec_prefix | input | XLEN | Prefix ORed into the handler address |
| embedded_model | input | 1 | Selects the embedded save rule |
| pm_wake | input | 1 | Entry is a wakeup from power-save |
| reloc_mode | input | 2 | High-address relocation mode |
| std_pc | output | XLEN | Standard pair, saved PC |
| std_st | output | XLEN | Standard pair, saved state |
| hyp_pc | output | XLEN | Hypervisor pair, saved PC |
| hyp_st | output | XLEN | Hypervisor pair, saved state |
| crit_pc | output | XLEN | Critical pair, saved PC |
| crit_st | output | XLEN | Critical pair, saved state |
| new_pc | output | XLEN | Handler address |
| new_state | output | XLEN | Handler machine state word |
| checkstop | output | 1 | Sticky halt after an unrecoverable machine check |
| vec_err | output | 1 | Undefined vector pulse |

## Verification
The bench goes after the masked floating-point program case. A design that misses it would overwrite the standard pair and jump when it should stay silent. The wakeup path is exercised with every listed cause and with a machine check. A wrong redirect shows up as the wrong table entry in `new_pc`, or as a cause in bits 21..18 where none belongs. The relocation checks cover both translation bits off and the non-hypervisor-to-hypervisor entry, where a design that ignores the suppression ORs high address bits into the handler address. An undefined vector entry must leave all registers untouched while `vec_err` pulses for exactly one cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W = 4;
  localparam int B_HV   = 60;
  localparam int B_FP   = 13;
  localparam int B_ME   = 12;
  localparam int B_FE0  = 11;
  localparam int B_FE1  = 8;
  localparam int B_IR   = 5;
  localparam int B_DR   = 4;
  localparam int B_RI   = 1;
  localparam int B_DOZE = 16;
  localparam int B_WAKE = 18;
  localparam logic [63:0] SAVE_CLR = 64'h0000_0000_783F_0000;

  typedef enum logic [CODE_W-1:0] {
    EC_RESET = 4'd0, EC_MCHK = 4'd1, EC_EXT = 4'd2, EC_DECR = 4'd3,
    EC_DBELL = 4'd4, EC_HDBELL = 4'd5, EC_HMAINT = 4'd6, EC_PROG = 4'd7,
    EC_SYSC = 4'd8, EC_HSTOR = 4'd9, EC_HDECR = 4'd10, EC_CRIT = 4'd11
  } exc_code_e;

  typedef enum logic [1:0] {
    PAIR_STD = 2'd0, PAIR_HYP = 2'd1, PAIR_CRIT = 2'd2
  } pair_e;
endpackage

// File: rtl/exc_cause.sv
module exc_cause
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        sub,
  input  logic [XLEN-1:0]   state,
  input  logic              embedded,
  input  logic              wake,
  output logic [CODE_W-1:0] eff_code,
  output logic [XLEN-1:0]   saved_st,
  output logic [XLEN-1:0]   base_st,
  output pair_e             pair,
  output logic              drop,
  output logic              pc_adv,
  output logic              halt_req
);
  logic [3:0] cause;

  always_comb begin
    eff_code = code;
    cause    = 4'h0;
    if (wake && code != EC_MCHK) begin
      unique case (code)
        EC_RESET:  cause = 4'h4;
        EC_EXT:    cause = 4'h8;
        EC_DECR:   cause = 4'h6;
        EC_DBELL:  cause = 4'h5;
        EC_HDBELL: cause = 4'h3;
        EC_HMAINT: cause = 4'hA;
        default:   cause = 4'h0;
      endcase
      eff_code = EC_RESET;
    end

    saved_st = embedded ? state : (state & ~SAVE_CLR[XLEN-1:0]);
    if (wake) begin
      saved_st[B_DOZE]      = 1'b1;
      saved_st[B_WAKE +: 4] = saved_st[B_WAKE +: 4] | cause;
    end

    base_st       = '0;
    base_st[B_ME] = state[B_ME];
    base_st[B_HV] = state[B_HV];
    pair     = PAIR_STD;
    drop     = 1'b0;
    pc_adv   = 1'b0;
    halt_req = 1'b0;

    unique case (eff_code)
      EC_MCHK: begin
        base_st[B_ME] = 1'b0;
        halt_req      = ~state[B_ME];
      end
      EC_PROG: begin
        unique case (sub)
          2'd0: begin
            if ((!state[B_FE0] && !state[B_FE1]) || !state[B_FP]) drop = 1'b1;
            else saved_st[20] = 1'b1;
          end
          2'd1:    saved_st[19] = 1'b1;
          2'd2:    saved_st[18] = 1'b1;
          default: saved_st[17] = 1'b1;
        endcase
      end
      EC_SYSC: begin
        pc_adv = 1'b1;
        if (sub[0]) base_st[B_HV] = 1'b1;
      end
      EC_HDBELL, EC_HMAINT, EC_HSTOR, EC_HDECR: begin
        pair          = PAIR_HYP;
        base_st[B_HV] = 1'b1;
        base_st[B_RI] = state[B_RI];
      end
      EC_CRIT: pair = PAIR_CRIT;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [CODE_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [CODE_W-1:0] rcode,
  input  logic [XLEN-1:0]   prefix,
  input  logic [1:0]        mode,
  input  logic              old_ir,
  input  logic              old_dr,
  input  logic              hv_enter,
  output logic [XLEN-1:0]   vec,
  output logic              bad,
  output logic              xlat_on
);
  localparam int NENT = 1 << CODE_W;
  localparam logic [XLEN-1:0] REL_LOW  = XLEN'(64'h0000_0000_0001_8000);
  localparam logic [XLEN-1:0] REL_HIGH = XLEN'(64'hC000_0000_0000_4000);

  logic [XLEN-1:0] table_q [NENT];
  logic [XLEN-1:0] raw;
  logic            allow;

  always_ff @(posedge clk) begin
    if (we) table_q[waddr] <= wdata;
  end

  assign raw = table_q[rcode];
  assign bad = &raw;

  always_comb begin
    allow   = old_ir && old_dr && !hv_enter;
    vec     = raw | prefix;
    xlat_on = 1'b0;
    if (allow) begin
      unique case (mode)
        2'd1: begin vec = vec | REL_LOW;  xlat_on = 1'b1; end
        2'd3: begin vec = vec | REL_HIGH; xlat_on = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [CODE_W-1:0] tbl_addr,
  input  logic [XLEN-1:0]   tbl_data,
  input  logic              take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [1:0]        exc_sub,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_state,
  input  logic [XLEN-1:0]   vec_prefix,
  input  logic              embedded_model,
  input  logic              pm_wake,
  input  logic [1:0]        reloc_mode,
  output logic [XLEN-1:0]   std_pc,
  output logic [XLEN-1:0]   std_st,
  output logic [XLEN-1:0]   hyp_pc,
  output logic [XLEN-1:0]   hyp_st,
  output logic [XLEN-1:0]   crit_pc,
  output logic [XLEN-1:0]   crit_st,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_state,
  output logic              checkstop,
  output logic              vec_err
);
  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   saved_st, base_st, vec, save_pc, next_st;
  pair_e             pair;
  logic              drop, pc_adv, halt_req, bad, xlat_on, upd;

  exc_cause #(.XLEN(XLEN)) u_cause (
    .code(exc_code), .sub(exc_sub), .state(cur_state),
    .embedded(embedded_model), .wake(pm_wake),
    .eff_code(eff_code), .saved_st(saved_st), .base_st(base_st),
    .pair(pair), .drop(drop), .pc_adv(pc_adv), .halt_req(halt_req)
  );

  exc_vector #(.XLEN(XLEN)) u_vec (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .rcode(eff_code), .prefix(vec_prefix), .mode(reloc_mode),
    .old_ir(cur_state[B_IR]), .old_dr(cur_state[B_DR]),
    .hv_enter(base_st[B_HV] && !cur_state[B_HV]),
    .vec(vec), .bad(bad), .xlat_on(xlat_on)
  );

  assign upd     = take && !drop && !bad;
  assign save_pc = pc_adv ? cur_pc + XLEN'(4) : cur_pc;

  always_comb begin
    next_st = base_st;
    if (xlat_on) begin
      next_st[B_IR] = 1'b1;
      next_st[B_DR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      std_pc <= '0; std_st <= '0; hyp_pc <= '0; hyp_st <= '0;
      crit_pc <= '0; crit_st <= '0; new_pc <= '0; new_state <= '0;
      checkstop <= 1'b0; vec_err <= 1'b0;
    end else begin
      vec_err <= take && !drop && bad;
      if (upd) begin
        unique case (pair)
          PAIR_HYP:  begin hyp_pc  <= save_pc; hyp_st  <= saved_st; end
          PAIR_CRIT: begin crit_pc <= save_pc; crit_st <= saved_st; end
          default:   begin std_pc  <= save_pc; std_st  <= saved_st; end
        endcase
        new_pc    <= vec;
        new_state <= next_st;
        if (halt_req) checkstop <= 1'b1;
      end
    end
  end

  p_err_no_update_r14: assert property (@(posedge clk) disable iff (rst)
    vec_err |-> $stable(new_pc) && $stable(new_state) && $stable(std_st));

  p_checkstop_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> checkstop);

  p_drop_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (take && drop) |=> $stable(new_pc) && $stable(std_pc) && !vec_err);

  p_hyp_sets_hv_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && pair == PAIR_HYP) |=> new_state[B_HV] && $stable(std_pc) && $stable(crit_pc));

  p_mchk_clears_me_r9: assert property (@(posedge clk) disable iff (rst)
    (upd && eff_code == EC_MCHK) |=> !new_state[B_ME]);
endmodule

// File: tb/exc_entry_gen_test.sv
module exc_entry_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_addr = '0;
  logic [63:0] tbl_data = '0;
  logic        take = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [1:0]  exc_sub = '0;
  logic [63:0] cur_pc = '0, cur_state = '0, vec_prefix = '0;
  logic        embedded_model = 1'b0, pm_wake = 1'b0;
  logic [1:0]  reloc_mode = '0;
  logic [63:0] std_pc, std_st, hyp_pc, hyp_st, crit_pc, crit_st, new_pc, new_state;
  logic        checkstop, vec_err;

  int nchk = 0;
  int nfail = 0;

  logic [63:0] m_tbl [16];
  logic [63:0] m_spc, m_sst, m_hpc, m_hst, m_cpc, m_cst, m_npc, m_nst;
  logic        m_halt, m_err;

  always #2 clk = ~clk;

  exc_entry_gen uut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .take(take), .exc_code(exc_code), .exc_sub(exc_sub), .cur_pc(cur_pc),
    .cur_state(cur_state), .vec_prefix(vec_prefix), .embedded_model(embedded_model),
    .pm_wake(pm_wake), .reloc_mode(reloc_mode), .std_pc(std_pc), .std_st(std_st),
    .hyp_pc(hyp_pc), .hyp_st(hyp_st), .crit_pc(crit_pc), .crit_st(crit_st),
    .new_pc(new_pc), .new_state(new_state), .checkstop(checkstop), .vec_err(vec_err)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "std_pc", std_pc, m_spc);     chk(req, "std_st", std_st, m_sst);
    chk(req, "hyp_pc", hyp_pc, m_hpc);     chk(req, "hyp_st", hyp_st, m_hst);
    chk(req, "crit_pc", crit_pc, m_cpc);   chk(req, "crit_st", crit_st, m_cst);
    chk(req, "new_pc", new_pc, m_npc);     chk(req, "new_state", new_state, m_nst);
    chk(req, "checkstop", {63'b0, checkstop}, {63'b0, m_halt});
    chk(req, "vec_err", {63'b0, vec_err}, {63'b0, m_err});
  endtask

  task automatic clear_model();
    m_spc = '0; m_sst = '0; m_hpc = '0; m_hst = '0; m_cpc = '0; m_cst = '0;
    m_npc = '0; m_nst = '0; m_halt = 1'b0; m_err = 1'b0;
  endtask

  // Expected update computed from the requirement text
  task automatic predict(input logic [3:0] code, input logic [1:0] sub, input logic [63:0] pc,
                         input logic [63:0] st, input logic emb, input logic wake,
                         input logic [1:0] mode, input logic [63:0] pfx);
    logic [3:0]  ec;
    logic [3:0]  wc;
    logic [63:0] sv, ns, vec, spc, raw;
    int          pr;
    logic        drop;
    ec = code; wc = 4'h0; pr = 0; drop = 1'b0; spc = pc;
    sv = emb ? st : (st & ~64'h783F0000);
    if (wake) begin
      sv = sv | (64'h1 << 16);
      if (code != 4'd1) begin
        case (code)
          4'd0: wc = 4'h4;  4'd2: wc = 4'h8;  4'd3: wc = 4'h6;
          4'd4: wc = 4'h5;  4'd5: wc = 4'h3;  4'd6: wc = 4'hA;
          default: wc = 4'h0;
        endcase
        sv = sv | ({60'b0, wc} << 18);
        ec = 4'd0;
      end
    end
    ns = st & ((64'h1 << 60) | (64'h1 << 12));
    case (ec)
      4'd1: ns = ns & ~(64'h1 << 12);
      4'd7: case (sub)
              2'd0: if ((!st[11] && !st[8]) || !st[13]) drop = 1'b1; else sv = sv | 64'h100000;
              2'd1: sv = sv | 64'h80000;
              2'd2: sv = sv | 64'h40000;
              default: sv = sv | 64'h20000;
            endcase
      4'd8: begin spc = pc + 64'd4; if (sub[0]) ns = ns | (64'h1 << 60); end
      4'd5, 4'd6, 4'd9, 4'd10: begin pr = 1; ns = ns | (64'h1 << 60) | (st & 64'h2); end
      4'd11: pr = 2;
      default: ;
    endcase
    raw = m_tbl[ec];
    m_err = 1'b0;
    if (!drop) begin
      if (raw == 64'hFFFF_FFFF_FFFF_FFFF) m_err = 1'b1;
      else begin
        vec = raw | pfx;
        if (st[5] && st[4] && !(ns[60] && !st[60])) begin
          if (mode == 2'd1) begin vec = vec | 64'h18000; ns = ns | 64'h30; end
          if (mode == 2'd3) begin vec = vec | 64'hC000_0000_0000_4000; ns = ns | 64'h30; end
        end
        if (pr == 1)      begin m_hpc = spc; m_hst = sv; end
        else if (pr == 2) begin m_cpc = spc; m_cst = sv; end
        else              begin m_spc = spc; m_sst = sv; end
        m_npc = vec; m_nst = ns;
        if (ec == 4'd1 && !st[12]) m_halt = 1'b1;
      end
    end
  endtask

  task automatic fire(input string req, input logic [3:0] code, input logic [1:0] sub,
                      input logic [63:0] pc, input logic [63:0] st, input logic emb,
                      input logic wake, input logic [1:0] mode, input logic [63:0] pfx);
    @(negedge clk);
    exc_code = code; exc_sub = sub; cur_pc = pc; cur_state = st;
    embedded_model = emb; pm_wake = wake; reloc_mode = mode; vec_prefix = pfx;
    take = 1'b1;
    predict(code, sub, pc, st, emb, wake, mode, pfx);
    @(negedge clk);
    take = 1'b0;
    check_all(req);
    m_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    clear_model();
  endtask

  localparam logic [63:0] ST_BASE = 64'h1000_0000_0000_3933; // HV, FP, ME, FE0, FE1, IR, DR, RI set
  localparam logic [63:0] PC0     = 64'h0000_0000_0040_1000;
  localparam logic [63:0] PFX     = 64'h0000_0000_0100_0000;

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_model();
    for (int i = 0; i < 16; i++) m_tbl[i] = 64'(i) << 8;
    m_tbl[15] = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 4'(i); tbl_data = m_tbl[i];
    end
    @(negedge clk); tbl_we = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check_all("R1");

    // R2 R3 R11: plain code, both save rules
    fire("R2", 4'd12, 2'd0, PC0, 64'hFFFF_FFFF_FFFF_FFCF, 1'b0, 1'b0, 2'd0, PFX);
    fire("R2", 4'd12, 2'd0, PC0, 64'hFFFF_FFFF_FFFF_FFCF, 1'b1, 1'b0, 2'd0, PFX);
    fire("R3", 4'd3, 2'd0, PC0 + 64'h20, 64'h0000_0000_0000_EFCF, 1'b0, 1'b0, 2'd1, 64'h0);
    fire("R11", 4'd4, 2'd0, PC0, ST_BASE, 1'b0, 1'b0, 2'd0, 64'h0000_0000_0200_0003);
    // R4 program subcauses
    for (int s = 0; s < 4; s++) fire("R4", 4'd7, 2'(s), PC0, ST_BASE, 1'b0, 1'b0, 2'd0, PFX);
    // R5 masked floating-point program exceptions
    fire("R5", 4'd7, 2'd0, PC0 + 64'h80, ST_BASE & ~64'h900, 1'b0, 1'b0, 2'd0, PFX);
    fire("R5", 4'd7, 2'd0, PC0 + 64'h84, ST_BASE & ~64'h2000, 1'b0, 1'b0, 2'd1, PFX);
    // R6 system call
    fire("R6", 4'd8, 2'd0, PC0, ST_BASE & ~(64'h1 << 60), 1'b0, 1'b0, 2'd0, PFX);
    fire("R6", 4'd8, 2'd1, PC0, 64'h0000_0000_0000_1000, 1'b0, 1'b0, 2'd0, PFX);
    // R7 hypervisor class, R8 critical
    fire("R7", 4'd9, 2'd0, PC0 + 64'h300, ST_BASE, 1'b0, 1'b0, 2'd0, PFX);
    fire("R7", 4'd5, 2'd0, PC0 + 64'h304, ST_BASE & ~64'h2, 1'b0, 1'b0, 2'd0, PFX);
    fire("R8", 4'd11, 2'd0, PC0 + 64'h500, ST_BASE, 1'b1, 1'b0, 2'd0, PFX);
    // R12 relocation modes, R13 suppression
    for (int m = 0; m < 4; m++) fire("R12", 4'd2, 2'd0, PC0, ST_BASE, 1'b0, 1'b0, 2'(m), PFX);
    fire("R13", 4'd2, 2'd0, PC0, ST_BASE & ~64'h20, 1'b0, 1'b0, 2'd1, PFX);
    fire("R13", 4'd2, 2'd0, PC0, ST_BASE & ~64'h10, 1'b0, 1'b0, 2'd3, PFX);
    fire("R13", 4'd10, 2'd0, PC0, ST_BASE & ~(64'h1 << 60), 1'b0, 1'b0, 2'd1, PFX);
    fire("R13", 4'd10, 2'd0, PC0, ST_BASE, 1'b0, 1'b0, 2'd1, PFX);
    // R10 power-save wakeup
    for (int c = 0; c < 8; c++) fire("R10", 4'(c), 2'd1, PC0 + 64'h900, ST_BASE, 1'b0, 1'b1, 2'd0, PFX);
    // R14 undefined vector then idle
    fire("R14", 4'd15, 2'd0, PC0 + 64'hA00, ST_BASE, 1'b0, 1'b0, 2'd0, PFX);
    @(negedge clk);
    check_all("R14");
    // R9 machine check: enabled, then disabled
    fire("R9", 4'd1, 2'd0, PC0 + 64'h200, ST_BASE, 1'b0, 1'b0, 2'd1, PFX);
    fire("R9", 4'd1, 2'd0, PC0 + 64'h204, ST_BASE & ~64'h1000, 1'b0, 1'b0, 2'd0, PFX);
    fire("R9", 4'd12, 2'd0, PC0, ST_BASE, 1'b0, 1'b0, 2'd0, PFX);
    do_reset();
    @(negedge clk);
    check_all("R1");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] st;
      st = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) st = st | 64'h30;
      fire("R11", 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
           {32'h0, $urandom} & ~64'h3, st, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)),
           {44'h0, 20'($urandom)} & 64'hFF000);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule